// File: doc/BRIEF.md
# Checked Memory Slave Responder

This block answers accesses on an asynchronous strobe bus on behalf of a memory whose read data arrives with a check verdict. For each access it drives three active-low replies: acknowledge, bus error and halt. Address strobe, the address, an address-hit indication, a one-cycle check-done pulse and a check-failed flag are inputs. All inputs are synchronous to `clk`. A two-bit policy input, captured when the strobe opens an access, selects how a failed check is reported. Under the retry scheme, bus error and halt are raised together with no acknowledge. Under the trap scheme, bus error is raised together with acknowledge. Under the early scheme, acknowledge is given at once, and if the check later fails, bus error and halt are raised together.

An access that no slave claims (address-hit low) is ended by a watchdog with bus error once a fixed number of clocks has passed. Acknowledge and bus error are dropped on the clock after the strobe is seen negated. Halt is kept low for a fixed number of clocks after that, so the master's retry starts cleanly. Failures that ask for a retry are counted per address. When the same address has already been retried the maximum number of times, the next failure gets bus error alone, so the master traps instead of looping.

Top module: `mem_err_responder`

## Requirements
- R1: While and after synchronous reset, `ack_n`, `berr_n` and `halt_n` are all high and the block is idle.
- R2: Under policy 0 or 1, `ack_n` stays high until the check-done pulse is sampled. A passing check (`chk_fail`=0) under any policy gives `ack_n` low with `berr_n` and `halt_n` high, visible one clock after the pulse.
- R3: Under policy 0, a failing check drives `berr_n` and `halt_n` low on the same clock edge, one clock after the pulse, while `ack_n` stays high.
- R4: Under policy 1, a failing check drives `ack_n` and `berr_n` low on the same clock edge, one clock after the pulse, while `halt_n` stays high.
- R5: Under policy 2, with address-hit high, `ack_n` goes low one clock after the strobe is first sampled low, before any check. A later failing check adds `berr_n` and `halt_n` low together, one clock after the pulse, with `ack_n` still low.
- R6: Once a reply has been given, `ack_n` and `berr_n` return high one clock after `as_n` is sampled high.
- R7: When halt was asserted, `halt_n` stays low for exactly HOLD_CYCLES clocks after the edge that released acknowledge and bus error, then returns high.
- R8: With address-hit low, `berr_n` goes low with `ack_n` and `halt_n` high. It is seen low at the (TIMEOUT+1)th falling clock edge after the strobe is driven low. The count restarts for every access.
- R9: Failures under policy 0 or 2 to the same address are counted. The failure that follows MAX_RETRY such failures gives `berr_n` low with `halt_n` high and restarts the count. Any passing check, or a policy 1 failure, also restarts the count.
- R10: The policy is captured at the clock edge that first samples the strobe low. Later changes to `policy` during the access have no effect. Code 3 behaves as code 0.
- R11: If `as_n` returns high before the check or the watchdog answers, the access ends with no reply. A check-done pulse while idle produces no reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, active low |
| addr | input | AW | Access address, used by the retry counter |
| addr_hit | input | 1 | High when a decoded slave claims the address |
| chk_done | input | 1 | One-cycle pulse: read data and its check verdict are ready |
| chk_fail | input | 1 | Check verdict, qualified by chk_done; 1 = data bad |
| policy | input | 2 | 0 retry, 1 trap, 2 early acknowledge, 3 as 0 |
| ack_n | output | 1 | Data acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |
| halt_n | output | 1 | Halt, active low |

## Verification
The bench checks the exact reply combination for each policy with check results that arrive both late and immediately. A design that acknowledged early under policy 0 or 1, or raised halt with the trap reply, shows up as a wrong early-acknowledge flag or reply triplet. The retry cap is checked on the failure that exceeds the limit, and again after a passing access clears the count. An off-by-one in the limit, or a count that never clears, would give a halt where bus error alone is expected, or the reverse. Both the watchdog delay and the halt hold time are measured in clocks, so a counter that starts one cycle late or is not restarted gives a different count. A policy change in mid-access and a strobe dropped before any reply check that a design does not act on stale or live inputs it should ignore.

// File: rtl/mresp_pkg.sv
package mresp_pkg;

    typedef enum logic [1:0] {
        POL_RETRY = 2'd0,
        POL_TRAP  = 2'd1,
        POL_EARLY = 2'd2,
        POL_RSVD  = 2'd3
    } policy_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_ACKED = 3'd2,
        ST_DONE  = 3'd3,
        ST_HOLD  = 3'd4
    } rsp_state_e;

    // Internal reply, active high; inverted at the pins.
    typedef struct packed {
        logic ack;
        logic berr;
        logic halt;
    } rsp_t;

    localparam rsp_t RSP_NONE = '{ack: 1'b0, berr: 1'b0, halt: 1'b0};

    function automatic policy_e norm_policy(input logic [1:0] code);
        case (code)
            2'd1:    return POL_TRAP;
            2'd2:    return POL_EARLY;
            default: return POL_RETRY;
        endcase
    endfunction

    function automatic rsp_t pass_reply();
        rsp_t r;
        r      = RSP_NONE;
        r.ack  = 1'b1;
        return r;
    endfunction

    // Reply to a failed check; give_up suppresses the retry request.
    function automatic rsp_t fail_reply(input policy_e pol, input logic give_up);
        rsp_t r;
        r = RSP_NONE;
        case (pol)
            POL_TRAP: begin
                r.ack  = 1'b1;
                r.berr = 1'b1;
            end
            POL_EARLY: begin
                r.ack  = 1'b1;
                r.berr = 1'b1;
                r.halt = !give_up;
            end
            default: begin
                r.berr = 1'b1;
                r.halt = !give_up;
            end
        endcase
        return r;
    endfunction

    function automatic logic asks_retry(input policy_e pol);
        return pol != POL_TRAP;
    endfunction

endpackage

// File: rtl/mresp_tick_counter.sv
module mresp_tick_counter #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);  // R8

    AST_TICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));  // R7

endmodule

// File: rtl/mresp_retry_limiter.sv
module mresp_retry_limiter #(
    parameter int unsigned AW        = 16,
    parameter int unsigned MAX_RETRY = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          retry_evt,
    input  logic          clear_evt,
    output logic          give_up
);
    localparam int unsigned RW = $clog2(MAX_RETRY + 1);
    localparam logic [RW-1:0] CAP = RW'(MAX_RETRY);

    logic [RW-1:0] cnt;
    logic [AW-1:0] last_addr;
    logic          same_addr;

    assign same_addr = (cnt != '0) && (addr == last_addr);
    assign give_up   = same_addr && (cnt == CAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            last_addr <= '0;
        end else if (clear_evt) begin
            cnt <= '0;
        end else if (retry_evt) begin
            if (give_up) begin
                cnt <= '0;
            end else if (same_addr) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt       <= RW'(1);
                last_addr <= addr;
            end
        end
    end

    AST_RETRY_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt <= CAP);  // R9

    AST_GIVEUP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (retry_evt && give_up && !clear_evt) |=> (cnt == '0));  // R9

endmodule

// File: rtl/mem_err_responder.sv
module mem_err_responder
    import mresp_pkg::*;
#(
    parameter int unsigned AW          = 16,
    parameter int unsigned TIMEOUT     = 16,
    parameter int unsigned HOLD_CYCLES = 4,
    parameter int unsigned MAX_RETRY   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          as_n,
    input  logic [AW-1:0] addr,
    input  logic          addr_hit,
    input  logic          chk_done,
    input  logic          chk_fail,
    input  logic [1:0]    policy,
    output logic          ack_n,
    output logic          berr_n,
    output logic          halt_n
);
    rsp_state_e    state, state_n;
    rsp_t          rsp_q, rsp_n;
    policy_e       pol_q, pol_n;
    logic [AW-1:0] addr_q, addr_n;

    logic wd_expired;
    logic hold_done;
    logic give_up;
    logic retry_evt;
    logic clear_evt;

    mresp_tick_counter #(.LIMIT(TIMEOUT)) u_watchdog (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != ST_WAIT),
        .run     ((state == ST_WAIT) && !addr_hit),
        .expired (wd_expired)
    );

    mresp_tick_counter #(.LIMIT(HOLD_CYCLES)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != ST_HOLD),
        .run     (state == ST_HOLD),
        .expired (hold_done)
    );

    mresp_retry_limiter #(.AW(AW), .MAX_RETRY(MAX_RETRY)) u_retry (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr_q),
        .retry_evt (retry_evt),
        .clear_evt (clear_evt),
        .give_up   (give_up)
    );

    always_comb begin
        state_n   = state;
        rsp_n     = rsp_q;
        pol_n     = pol_q;
        addr_n    = addr_q;
        retry_evt = 1'b0;
        clear_evt = 1'b0;
        case (state)
            ST_IDLE: begin
                if (!as_n) begin
                    pol_n  = norm_policy(policy);
                    addr_n = addr;
                    if (norm_policy(policy) == POL_EARLY && addr_hit) begin
                        rsp_n   = pass_reply();
                        state_n = ST_ACKED;
                    end else begin
                        state_n = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (as_n) begin
                    rsp_n   = RSP_NONE;
                    state_n = ST_IDLE;
                end else if (wd_expired) begin
                    rsp_n      = RSP_NONE;
                    rsp_n.berr = 1'b1;
                    state_n    = ST_DONE;
                end else if (addr_hit && chk_done) begin
                    state_n = ST_DONE;
                    if (!chk_fail) begin
                        rsp_n     = pass_reply();
                        clear_evt = 1'b1;
                    end else begin
                        rsp_n     = fail_reply(pol_q, give_up);
                        retry_evt = asks_retry(pol_q);
                        clear_evt = !asks_retry(pol_q);
                    end
                end
            end
            ST_ACKED: begin
                if (as_n) begin
                    rsp_n   = RSP_NONE;
                    state_n = ST_IDLE;
                end else if (chk_done) begin
                    state_n = ST_DONE;
                    if (!chk_fail) begin
                        clear_evt = 1'b1;
                    end else begin
                        rsp_n     = fail_reply(POL_EARLY, give_up);
                        retry_evt = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                if (as_n) begin
                    rsp_n.ack  = 1'b0;
                    rsp_n.berr = 1'b0;
                    state_n    = rsp_q.halt ? ST_HOLD : ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (hold_done) begin
                    rsp_n.halt = 1'b0;
                    state_n    = ST_IDLE;
                end
            end
            default: begin
                rsp_n   = RSP_NONE;
                state_n = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            rsp_q  <= RSP_NONE;
            pol_q  <= POL_RETRY;
            addr_q <= '0;
        end else begin
            state  <= state_n;
            rsp_q  <= rsp_n;
            pol_q  <= pol_n;
            addr_q <= addr_n;
        end
    end

    assign ack_n  = !rsp_q.ack;
    assign berr_n = !rsp_q.berr;
    assign halt_n = !rsp_q.halt;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (ack_n && berr_n && halt_n));  // R1

    AST_ACK_AFTER_CHECK: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack_n) && pol_q != POL_EARLY) |-> $past(chk_done));  // R2

    AST_RETRY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (pol_q == POL_RETRY && !berr_n && !halt_n) |-> ack_n);  // R3

    AST_TRAP_PAIR: assert property (@(posedge clk) disable iff (rst)
        ($fell(berr_n) && pol_q == POL_TRAP && $past(chk_done && addr_hit))
            |-> (!ack_n && halt_n));  // R4

    AST_HALT_WITH_BERR: assert property (@(posedge clk) disable iff (rst)
        $fell(halt_n) |-> $fell(berr_n));  // R5

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($past(as_n) && $past(state == ST_DONE)) |-> (ack_n && berr_n));  // R6

    AST_HALT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_n) |-> (ack_n && berr_n));  // R7

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (ack_n && berr_n && halt_n));  // R11

endmodule

// File: tb/mem_err_responder_tb.sv
`timescale 1ns/1ps
module mem_err_responder_tb;
    localparam int AW          = 16;
    localparam int TIMEOUT     = 16;
    localparam int HOLD_CYCLES = 4;
    localparam int MAX_RETRY   = 2;
    localparam int NVEC        = 10;

    // Vector: [11:10] policy, [9] hit, [8] fail, [7:4] check delay,
    //         [3] early ack expected, [2:0] expected {ack,berr,halt} active high
    localparam logic [11:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 1'b0, 4'd0, 1'b0, 3'b100},
        {2'd0, 1'b1, 1'b0, 4'd5, 1'b0, 3'b100},
        {2'd0, 1'b1, 1'b1, 4'd2, 1'b0, 3'b011},
        {2'd1, 1'b1, 1'b0, 4'd1, 1'b0, 3'b100},
        {2'd1, 1'b1, 1'b1, 4'd3, 1'b0, 3'b110},
        {2'd2, 1'b1, 1'b0, 4'd0, 1'b1, 3'b100},
        {2'd2, 1'b1, 1'b1, 4'd4, 1'b1, 3'b111},
        {2'd3, 1'b1, 1'b1, 4'd1, 1'b0, 3'b011},
        {2'd3, 1'b1, 1'b0, 4'd0, 1'b0, 3'b100},
        {2'd2, 1'b1, 1'b1, 4'd0, 1'b1, 3'b111}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          as_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          addr_hit = 1'b0;
    logic          chk_done = 1'b0;
    logic          chk_fail = 1'b0;
    logic [1:0]    policy = 2'd0;
    logic          ack_n, berr_n, halt_n;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mem_err_responder #(
        .AW(AW), .TIMEOUT(TIMEOUT), .HOLD_CYCLES(HOLD_CYCLES), .MAX_RETRY(MAX_RETRY)
    ) u_dut (
        .clk(clk), .rst(rst), .as_n(as_n), .addr(addr), .addr_hit(addr_hit),
        .chk_done(chk_done), .chk_fail(chk_fail), .policy(policy),
        .ack_n(ack_n), .berr_n(berr_n), .halt_n(halt_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] outs();
        return {!ack_n, !berr_n, !halt_n};
    endfunction

    // One access with a check verdict after dly clocks; returns the observations.
    task automatic run_access(input logic [1:0] pol, input logic hit, input logic fail,
                              input int dly, input logic [AW-1:0] a,
                              output logic early, output logic [2:0] rsp,
                              output logic released, output int hold);
        @(negedge clk);
        as_n = 1'b0; policy = pol; addr = a; addr_hit = hit;
        @(negedge clk);
        early = !ack_n;
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            if (!ack_n) early = 1'b1;
        end
        chk_done = 1'b1; chk_fail = fail;
        @(negedge clk);
        chk_done = 1'b0; chk_fail = 1'b0;
        rsp = outs();
        as_n = 1'b1; addr_hit = 1'b0;
        @(negedge clk);
        released = ack_n && berr_n;
        hold = 0;
        while (!halt_n && hold < 32) begin
            hold++;
            @(negedge clk);
        end
    endtask

    function automatic string tag_for(input logic [1:0] pol, input logic fail);
        if (pol == 2'd2) return "R5";
        if (!fail)       return "R2";
        if (pol == 2'd1) return "R4";
        if (pol == 2'd3) return "R10";
        return "R3";
    endfunction

    task automatic retry_step(input logic [1:0] pol, input logic fail, input logic [AW-1:0] a,
                              input logic [2:0] exp_rsp, input string what);
        logic e, rel;
        logic [2:0] r;
        int h;
        run_access(pol, 1'b1, fail, 1, a, e, r, rel, h);
        check("R9", what, r, exp_rsp);
        check("R9", {what, " hold"}, h, exp_rsp[0] ? HOLD_CYCLES : 0);
    endtask

    task automatic watchdog_access(input string what);
        int cnt;
        @(negedge clk);
        as_n = 1'b0; policy = 2'd0; addr = 16'h0F00; addr_hit = 1'b0;
        @(negedge clk);
        cnt = 0;
        while (berr_n && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        check("R8", {what, " clocks to bus error"}, cnt, TIMEOUT);
        check("R8", {what, " ack/halt idle"}, {ack_n, halt_n}, 2'b11);
        as_n = 1'b1;
        @(negedge clk);
        check("R6", {what, " release"}, {ack_n, berr_n, halt_n}, 3'b111);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic e, rel;
        logic [2:0] r;
        int h;

        repeat (3) @(negedge clk);
        check("R1", "outputs during reset", outs(), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "outputs after reset", outs(), 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] vp;
            logic       vf;
            vp = VEC[i][11:10];
            vf = VEC[i][8];
            run_access(vp, VEC[i][9], vf, int'(VEC[i][7:4]), AW'(16'h0100 + i), e, r, rel, h);
            check(vp == 2'd2 ? "R5" : "R2", $sformatf("vec %0d early ack", i), e, VEC[i][3]);
            check(tag_for(vp, vf), $sformatf("vec %0d reply", i), r, VEC[i][2:0]);
            check("R6", $sformatf("vec %0d release", i), rel, 1);
            check("R7", $sformatf("vec %0d halt hold", i), h, VEC[i][0] ? HOLD_CYCLES : 0);
        end

        // Retry cap at one address under policy 0
        retry_step(2'd0, 1'b1, 16'h00AA, 3'b011, "first retry");
        retry_step(2'd0, 1'b1, 16'h00AA, 3'b011, "second retry");
        retry_step(2'd0, 1'b1, 16'h00AA, 3'b010, "cap exceeded");
        retry_step(2'd0, 1'b1, 16'h00AA, 3'b011, "count restarted");
        retry_step(2'd0, 1'b1, 16'h00AA, 3'b011, "second after restart");
        retry_step(2'd0, 1'b0, 16'h00AA, 3'b100, "pass clears");
        retry_step(2'd0, 1'b1, 16'h00AA, 3'b011, "retry after pass");
        // Retry cap under policy 2 at a new address
        retry_step(2'd2, 1'b1, 16'h00BB, 3'b111, "early first");
        retry_step(2'd2, 1'b1, 16'h00BB, 3'b111, "early second");
        retry_step(2'd2, 1'b1, 16'h00BB, 3'b110, "early cap exceeded");

        // Watchdog, twice to show the restart
        watchdog_access("unmapped 1");
        watchdog_access("unmapped 2");

        // Policy latched at strobe start
        @(negedge clk);
        as_n = 1'b0; policy = 2'd0; addr = 16'h0200; addr_hit = 1'b1;
        @(negedge clk);
        policy = 2'd1;
        @(negedge clk);
        check("R10", "no ack after policy change", ack_n, 1);
        chk_done = 1'b1; chk_fail = 1'b1;
        @(negedge clk);
        chk_done = 1'b0; chk_fail = 1'b0;
        check("R10", "latched policy reply", outs(), 3'b011);
        as_n = 1'b1; addr_hit = 1'b0; policy = 2'd0;
        repeat (HOLD_CYCLES + 2) @(negedge clk);
        check("R7", "halt gone after hold", halt_n, 1);

        // Strobe dropped before any reply
        @(negedge clk);
        as_n = 1'b0; policy = 2'd0; addr = 16'h0300; addr_hit = 1'b1;
        repeat (2) @(negedge clk);
        as_n = 1'b1;
        @(negedge clk);
        check("R11", "aborted access silent", outs(), 0);
        chk_done = 1'b1; chk_fail = 1'b1;
        @(negedge clk);
        chk_done = 1'b0; chk_fail = 1'b0;
        @(negedge clk);
        check("R11", "stray check while idle", outs(), 0);
        run_access(2'd1, 1'b1, 1'b0, 1, 16'h0301, e, r, rel, h);
        check("R11", "access after abort", r, 3'b100);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule